// File: doc/BRIEF.md
# Sample FIFO with Conversion Counter and Interrupt Status

This block sits behind an analog sampling sequencer. Every converted sample arrives with a one-cycle valid strobe. The block stores it in a 1024-entry, 16-bit first-in first-out buffer. The host takes samples out through a 16-bit data port: each read strobe pops one entry.

The buffer has no occupancy register. Instead, a 16-bit down-counter steps once per conversion. The host works out how many samples have arrived by comparing successive counter readings. A value the host writes into the counter does not take effect at once. It is held in a staging register and loaded by the next conversion. Until that conversion, reads return the old count.

The block also keeps a data-ready pending flag, a sticky overrun flag, an interrupt enable and a 3-bit interrupt-level code, all reached through a byte-wide register port. The interrupt output follows the enable and the pending flag.

Top module: `sfifo_acq_top`

## Requirements
- R1: Popped samples leave in arrival order. `data_out` holds the popped value from the clock edge that samples `data_rd` high until the next successful pop.
- R2: The buffer holds 1024 samples. A sample that arrives while the buffer is full is dropped, even if a pop happens in the same cycle. A dropped sample sets the overrun flag, which is bit 5 of the status byte at offset 2. The flag stays set until an acknowledge write or a reset.
- R3: A pop while the buffer is empty leaves `data_out` unchanged and does not move the read position. The next sample pushed is the next one popped.
- R4: The conversion counter is read as the low byte at offset 8 and the high byte at offset 9. It decreases by one on every valid strobe, dropped samples included, and wraps from 0x0000 to 0xFFFF.
- R5: A write to offset 8 or 9 updates that byte of a staging value and arms a load. Counter reads keep returning the old count until the next valid strobe. That strobe loads the staged value instead of decrementing.
- R6: A sample written into an empty buffer sets the pending flag, which is bit 7 of the status byte at offset 2.
- R7: Any write to offset 4 clears the pending flag and the overrun flag. A flag that is set in the same cycle stays set.
- R8: `irq_out` is high exactly when the enable bit (bit 7 of the control byte at offset 5) and the pending flag are both 1.
- R9: Bits 6:4 of the control byte store the 3-bit level code. That code reads back and drives `irq_level`. Control bits 3:0 read as 0.
- R10: Reset clears all of the following: both flags, the control byte, the counter, the staged load, the buffer contents, `data_out` and `irq_out`. Unmapped offsets read 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| samp_valid | input | 1 | One conversion completed this cycle |
| samp_data | input | 16 | Converted sample |
| reg_addr | input | 4 | Register offset |
| reg_wr | input | 1 | Register write strobe |
| reg_wdata | input | 8 | Register write byte |
| reg_rdata | output | 8 | Register read byte for `reg_addr` (combinational) |
| data_rd | input | 1 | Pop one sample |
| data_out | output | 16 | Last popped sample |
| irq_out | output | 1 | Data-ready interrupt request |
| irq_level | output | 3 | Stored interrupt-level code |

## Verification
Suppose the buffer pointers slipped. The first pop after the slip would return a sample out of order or a stale one, and an empty pop would move the read position. Both show at `data_out` one cycle after the strobe. A counter that loaded its staged value too early, or decremented on the loading strobe, shows in the very next byte read at offset 8 or 9. A pending or overrun flag that fails to hold, or clears when it should not, shows in the status byte and at `irq_out` on the cycle after the event. A full buffer that accepted one more sample shows only later, when the host drains the buffer: one sample too many, or a corrupted sequence.

// File: rtl/sfifo_pkg.sv
package sfifo_pkg;
    localparam int SAMPLE_W   = 16;
    localparam int FIFO_DEPTH = 1024;
    localparam int PTR_W      = $clog2(FIFO_DEPTH);
    localparam int FILL_W     = PTR_W + 1;
    localparam int CNT_W      = 16;
    localparam int CNT_BYTES  = CNT_W / 8;
    localparam int ADDR_W     = 4;
    localparam int LVL_W      = 3;

    localparam logic [ADDR_W-1:0] OFS_STATUS = 4'd2;
    localparam logic [ADDR_W-1:0] OFS_ACK    = 4'd4;
    localparam logic [ADDR_W-1:0] OFS_CTRL   = 4'd5;
    localparam logic [ADDR_W-1:0] OFS_CNT    = 4'd8;

    typedef struct packed {
        logic             en;
        logic [LVL_W-1:0] lvl;
    } ctrl_t;

    typedef struct packed {
        logic pend;
        logic ovr;
    } flags_t;

    function automatic logic [7:0] status_byte(flags_t f);
        return {f.pend, 1'b0, f.ovr, 5'b0};
    endfunction

    function automatic logic [7:0] ctrl_byte(ctrl_t c);
        return {c.en, c.lvl, 4'b0};
    endfunction
endpackage

// File: rtl/sfifo_store.sv
module sfifo_store
    import sfifo_pkg::*;
(
    input  logic                clk,
    input  logic                rst,
    input  logic                push,
    input  logic [SAMPLE_W-1:0] wdata,
    input  logic                pop,
    output logic [SAMPLE_W-1:0] rdata,
    output logic                full,
    output logic                empty,
    output logic [FILL_W-1:0]   fill
);
    logic [SAMPLE_W-1:0] mem [FIFO_DEPTH];
    logic [PTR_W-1:0]    wr_ptr, rd_ptr;
    logic                push_ok, pop_ok;

    assign full    = (fill == FILL_W'(FIFO_DEPTH));
    assign empty   = (fill == '0);
    assign push_ok = push && !full;
    assign pop_ok  = pop && !empty;

    function automatic logic [PTR_W-1:0] bump(logic [PTR_W-1:0] p);
        return (p == PTR_W'(FIFO_DEPTH - 1)) ? '0 : p + 1'b1;
    endfunction

    always_ff @(posedge clk) begin
        if (push_ok) mem[wr_ptr] <= wdata;
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            wr_ptr <= '0;
            rd_ptr <= '0;
            fill   <= '0;
            rdata  <= '0;
        end else begin
            if (push_ok) wr_ptr <= bump(wr_ptr);
            if (pop_ok) begin
                rd_ptr <= bump(rd_ptr);
                rdata  <= mem[rd_ptr];
            end
            if (push_ok && !pop_ok)      fill <= fill + 1'b1;
            else if (pop_ok && !push_ok) fill <= fill - 1'b1;
        end
    end
endmodule

// File: rtl/sfifo_convcnt.sv
module sfifo_convcnt
    import sfifo_pkg::*;
(
    input  logic                 clk,
    input  logic                 rst,
    input  logic                 conv,
    input  logic [CNT_BYTES-1:0] byte_we,
    input  logic [7:0]           wbyte,
    output logic [CNT_W-1:0]     count,
    output logic                 armed
);
    logic [7:0]       stage_b [CNT_BYTES];
    logic [CNT_W-1:0] stage;

    for (genvar b = 0; b < CNT_BYTES; b++) begin : g_lane
        always_ff @(posedge clk) begin
            if (rst)             stage_b[b] <= '0;
            else if (byte_we[b]) stage_b[b] <= wbyte;
        end
        assign stage[b*8 +: 8] = stage_b[b];
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            count <= '0;
            armed <= 1'b0;
        end else begin
            if (conv) count <= armed ? stage : count - 1'b1;
            if (|byte_we)  armed <= 1'b1;
            else if (conv) armed <= 1'b0;
        end
    end
endmodule

// File: rtl/sfifo_irqstat.sv
module sfifo_irqstat
    import sfifo_pkg::*;
(
    input  logic   clk,
    input  logic   rst,
    input  logic   set_pend,
    input  logic   set_ovr,
    input  logic   ack,
    input  logic   ctrl_we,
    input  logic [7:0] ctrl_wdata,
    output flags_t flags,
    output ctrl_t  ctrl,
    output logic   irq
);
    always_ff @(posedge clk) begin
        if (rst) begin
            flags <= '0;
            ctrl  <= '0;
        end else begin
            if (set_pend) flags.pend <= 1'b1;
            else if (ack) flags.pend <= 1'b0;
            if (set_ovr)  flags.ovr  <= 1'b1;
            else if (ack) flags.ovr  <= 1'b0;
            if (ctrl_we) begin
                ctrl.en  <= ctrl_wdata[7];
                ctrl.lvl <= ctrl_wdata[6:4];
            end
        end
    end

    assign irq = ctrl.en && flags.pend;
endmodule

// File: rtl/sfifo_acq_top.sv
module sfifo_acq_top
    import sfifo_pkg::*;
(
    input  logic                clk,
    input  logic                rst,
    input  logic                samp_valid,
    input  logic [SAMPLE_W-1:0] samp_data,
    input  logic [ADDR_W-1:0]   reg_addr,
    input  logic                reg_wr,
    input  logic [7:0]          reg_wdata,
    output logic [7:0]          reg_rdata,
    input  logic                data_rd,
    output logic [SAMPLE_W-1:0] data_out,
    output logic                irq_out,
    output logic [LVL_W-1:0]    irq_level
);
    logic                 full, empty;
    logic [FILL_W-1:0]    fill;
    logic [CNT_W-1:0]     conv_cnt;
    logic                 cnt_armed;
    logic [CNT_BYTES-1:0] cnt_we;
    flags_t               flags;
    ctrl_t                ctrl;

    sfifo_store u_store (
        .clk(clk), .rst(rst), .push(samp_valid), .wdata(samp_data),
        .pop(data_rd), .rdata(data_out), .full(full), .empty(empty), .fill(fill)
    );

    for (genvar b = 0; b < CNT_BYTES; b++) begin : g_cntdec
        assign cnt_we[b] = reg_wr && (reg_addr == OFS_CNT + ADDR_W'(b));
    end

    sfifo_convcnt u_cnt (
        .clk(clk), .rst(rst), .conv(samp_valid), .byte_we(cnt_we),
        .wbyte(reg_wdata), .count(conv_cnt), .armed(cnt_armed)
    );

    sfifo_irqstat u_irq (
        .clk(clk), .rst(rst),
        .set_pend(samp_valid && empty),
        .set_ovr(samp_valid && full),
        .ack(reg_wr && reg_addr == OFS_ACK),
        .ctrl_we(reg_wr && reg_addr == OFS_CTRL),
        .ctrl_wdata(reg_wdata),
        .flags(flags), .ctrl(ctrl), .irq(irq_out)
    );

    assign irq_level = ctrl.lvl;

    always_comb begin
        reg_rdata = '0;
        if (reg_addr == OFS_STATUS) reg_rdata = status_byte(flags);
        if (reg_addr == OFS_CTRL)   reg_rdata = ctrl_byte(ctrl);
        for (int b = 0; b < CNT_BYTES; b++) begin
            if (reg_addr == OFS_CNT + ADDR_W'(b)) reg_rdata = conv_cnt[b*8 +: 8];
        end
    end
endmodule

// File: rtl/sfifo_acq_chk.sv
module sfifo_acq_chk
    import sfifo_pkg::*;
(
    input logic              clk,
    input logic              rst,
    input logic              samp_valid,
    input logic              reg_wr,
    input logic [ADDR_W-1:0] reg_addr,
    input logic              irq_out,
    input logic              pend,
    input logic              ovr,
    input logic              en,
    input logic              full,
    input logic              empty,
    input logic [FILL_W-1:0] fill,
    input logic [CNT_W-1:0]  cnt,
    input logic              armed
);
    assert_irq_enable_R8: assert property (@(posedge clk) disable iff (rst)
        irq_out |-> en);
    assert_irq_pending_R8: assert property (@(posedge clk) disable iff (rst)
        irq_out |-> pend);
    assert_ovr_on_full_R2: assert property (@(posedge clk) disable iff (rst)
        (samp_valid && full) |=> ovr);
    assert_ovr_sticky_R2: assert property (@(posedge clk) disable iff (rst)
        (ovr && !(reg_wr && reg_addr == OFS_ACK)) |=> ovr);
    assert_pend_first_R6: assert property (@(posedge clk) disable iff (rst)
        (samp_valid && empty) |=> pend);
    assert_cnt_dec_R4: assert property (@(posedge clk) disable iff (rst)
        (samp_valid && !armed) |=> (cnt == CNT_W'($past(cnt) - 1'b1)));
    assert_cnt_hold_R5: assert property (@(posedge clk) disable iff (rst)
        !samp_valid |=> $stable(cnt));

    always_comb begin
        if (!rst) assert_fill_bound_R2: assert (fill <= FILL_W'(FIFO_DEPTH));
    end
endmodule

bind sfifo_acq_top sfifo_acq_chk u_chk (
    .clk(clk), .rst(rst), .samp_valid(samp_valid), .reg_wr(reg_wr),
    .reg_addr(reg_addr), .irq_out(irq_out), .pend(flags.pend), .ovr(flags.ovr),
    .en(ctrl.en), .full(full), .empty(empty), .fill(fill), .cnt(conv_cnt),
    .armed(cnt_armed)
);

// File: tb/sfifo_acq_top_bench.sv
`timescale 1ns/1ps
module sfifo_acq_top_bench;
    logic        clk = 1'b0;
    logic        rst = 1'b1;
    logic        samp_valid = 1'b0;
    logic [15:0] samp_data = '0;
    logic [3:0]  reg_addr = '0;
    logic        reg_wr = 1'b0;
    logic [7:0]  reg_wdata = '0;
    logic [7:0]  reg_rdata;
    logic        data_rd = 1'b0;
    logic [15:0] data_out;
    logic        irq_out;
    logic [2:0]  irq_level;

    int errors = 0;
    int checks = 0;
    bit done = 0;

    always #2.5 clk = ~clk;

    sfifo_acq_top u_sfifo_acq_top (
        .clk(clk), .rst(rst), .samp_valid(samp_valid), .samp_data(samp_data),
        .reg_addr(reg_addr), .reg_wr(reg_wr), .reg_wdata(reg_wdata),
        .reg_rdata(reg_rdata), .data_rd(data_rd), .data_out(data_out),
        .irq_out(irq_out), .irq_level(irq_level)
    );

    task automatic check(input logic [15:0] act, input logic [15:0] exp, input int req, input string what);
        checks++;
        if (act !== exp) begin
            errors++;
            $display("FAIL R%0d %s actual=%h expected=%h", req, what, act, exp);
        end
    endtask

    task automatic wr(input logic [3:0] a, input logic [7:0] d);
        @(negedge clk); reg_addr = a; reg_wdata = d; reg_wr = 1'b1;
        @(negedge clk); reg_wr = 1'b0;
    endtask

    task automatic rd(input logic [3:0] a, output logic [7:0] d);
        @(negedge clk); reg_addr = a; #1; d = reg_rdata;
    endtask

    task automatic push(input logic [15:0] s);
        @(negedge clk); samp_data = s; samp_valid = 1'b1;
        @(negedge clk); samp_valid = 1'b0;
    endtask

    task automatic pop();
        @(negedge clk); data_rd = 1'b1;
        @(negedge clk); data_rd = 1'b0;
    endtask

    // entry: op[41:40] req[39:36] addr[35:32] data[31:16] exp[15:0]
    // op 0 write, 1 read and check, 2 push, 3 pop and check, 4 check irq_out
    localparam int NV = 37;
    localparam logic [41:0] VEC [NV] = '{
        {2'd1, 4'd10, 4'd2, 16'h0,    16'h0000}, // R10 status clear
        {2'd1, 4'd10, 4'd8, 16'h0,    16'h0000}, // R10 counter low
        {2'd1, 4'd10, 4'd9, 16'h0,    16'h0000}, // R10 counter high
        {2'd0, 4'd10, 4'd0, 16'h0,    16'h0000}, // R10 irq low (op4 below)
        {2'd0, 4'd9,  4'd5, 16'h00B0, 16'h0000}, // R9 enable, level 3
        {2'd1, 4'd9,  4'd5, 16'h0,    16'h00B0}, // R9 readback
        {2'd2, 4'd6,  4'd0, 16'h1234, 16'h0000}, // R6 push into empty
        {2'd1, 4'd6,  4'd2, 16'h0,    16'h0080}, // R6 pending
        {2'd0, 4'd8,  4'd0, 16'h0,    16'h0001}, // R8 irq high (op4 below)
        {2'd1, 4'd4,  4'd8, 16'h0,    16'h00FF}, // R4 wrap low
        {2'd1, 4'd4,  4'd9, 16'h0,    16'h00FF}, // R4 wrap high
        {2'd2, 4'd1,  4'd0, 16'hABCD, 16'h0000}, // R1
        {2'd2, 4'd1,  4'd0, 16'h0F0F, 16'h0000}, // R1
        {2'd3, 4'd1,  4'd0, 16'h0,    16'h1234}, // R1 order
        {2'd3, 4'd1,  4'd0, 16'h0,    16'hABCD}, // R1 order
        {2'd3, 4'd1,  4'd0, 16'h0,    16'h0F0F}, // R1 order
        {2'd0, 4'd7,  4'd4, 16'h0,    16'h0000}, // R7 acknowledge
        {2'd1, 4'd7,  4'd2, 16'h0,    16'h0000}, // R7 cleared
        {2'd0, 4'd8,  4'd0, 16'h0,    16'h0000}, // R8 irq low (op4 below)
        {2'd0, 4'd5,  4'd8, 16'h0010, 16'h0000}, // R5 stage low
        {2'd0, 4'd5,  4'd9, 16'h0000, 16'h0000}, // R5 stage high
        {2'd1, 4'd5,  4'd8, 16'h0,    16'h00FD}, // R5 old count low
        {2'd1, 4'd5,  4'd9, 16'h0,    16'h00FF}, // R5 old count high
        {2'd2, 4'd5,  4'd0, 16'h5555, 16'h0000}, // R5 loading conversion
        {2'd1, 4'd5,  4'd8, 16'h0,    16'h0010}, // R5 loaded low
        {2'd1, 4'd5,  4'd9, 16'h0,    16'h0000}, // R5 loaded high
        {2'd1, 4'd6,  4'd2, 16'h0,    16'h0080}, // R6 pending again
        {2'd2, 4'd4,  4'd0, 16'h6666, 16'h0000}, // R4
        {2'd1, 4'd4,  4'd8, 16'h0,    16'h000F}, // R4 decrement after load
        {2'd3, 4'd1,  4'd0, 16'h0,    16'h5555}, // R1
        {2'd3, 4'd1,  4'd0, 16'h0,    16'h6666}, // R1
        {2'd0, 4'd8,  4'd5, 16'h0030, 16'h0000}, // R8 disable
        {2'd0, 4'd7,  4'd4, 16'h0,    16'h0000}, // R7 acknowledge
        {2'd2, 4'd8,  4'd0, 16'h7777, 16'h0000}, // R8 pending without enable
        {2'd0, 4'd8,  4'd0, 16'h0,    16'h0000}, // R8 irq low (op4 below)
        {2'd1, 4'd6,  4'd2, 16'h0,    16'h0080}, // R6 pending set
        {2'd3, 4'd1,  4'd0, 16'h0,    16'h7777}  // R1
    };
    // irq checks: entries whose op field is 0 with addr 0 are treated as op 4
    function automatic bit is_irq_chk(logic [41:0] v);
        return v[41:40] == 2'd0 && v[35:32] == 4'd0;
    endfunction

    initial begin
        repeat (3) @(negedge clk);
        rst = 1'b0;
        for (int i = 0; i < NV; i++) begin
            logic [41:0] v;
            logic [7:0]  b;
            v = VEC[i];
            if (is_irq_chk(v)) begin
                @(negedge clk);
                check({15'd0, irq_out}, v[15:0], int'(v[39:36]), $sformatf("vec %0d irq_out", i));
            end else begin
                case (v[41:40])
                    2'd0: wr(v[35:32], v[23:16]);
                    2'd1: begin
                        rd(v[35:32], b);
                        check({8'd0, b}, v[15:0], int'(v[39:36]), $sformatf("vec %0d reg %0d", i, v[35:32]));
                    end
                    2'd2: push(v[31:16]);
                    default: begin
                        pop();
                        check(data_out, v[15:0], int'(v[39:36]), $sformatf("vec %0d data_out", i));
                    end
                endcase
            end
        end

        begin : directed
            logic [7:0]  b, lo, hi;
            logic [15:0] c0, c1;
            int bad;
            // R3: empty pop leaves data_out and pointer alone
            pop();
            check(data_out, 16'h7777, 3, "R3 empty pop holds data_out");
            push(16'h1111);
            pop();
            check(data_out, 16'h1111, 3, "R3 no underflow");
            wr(4'd4, 8'h00);
            // R7: set in same cycle as acknowledge wins
            @(negedge clk); samp_data = 16'h2222; samp_valid = 1'b1;
            reg_addr = 4'd4; reg_wr = 1'b1;
            @(negedge clk); samp_valid = 1'b0; reg_wr = 1'b0;
            rd(4'd2, b);
            check({8'd0, b}, 16'h0080, 7, "R7 set beats clear");
            pop();
            check(data_out, 16'h2222, 1, "R1 after race");
            wr(4'd4, 8'h00);
            // R2: fill to depth, then overflow
            rd(4'd8, lo); rd(4'd9, hi); c0 = {hi, lo};
            for (int i = 0; i < 1024; i++) push(16'(i + 16'h0100));
            rd(4'd2, b);
            check({8'd0, b}, 16'h0080, 2, "R2 full without overrun");
            push(16'hDEAD);
            rd(4'd2, b);
            check({8'd0, b}, 16'h00A0, 2, "R2 overrun set");
            rd(4'd8, lo); rd(4'd9, hi); c1 = {hi, lo};
            check(c1, 16'(c0 - 16'd1025), 4, "R4 dropped sample counted");
            bad = 0;
            for (int i = 0; i < 1024; i++) begin
                pop();
                if (data_out !== 16'(i + 16'h0100)) bad++;
            end
            check(16'(bad), 16'd0, 2, "R2 drained 1024 in order");
            pop();
            check(data_out, 16'h04FF, 3, "R3 pop past empty");
            rd(4'd2, b);
            check({8'd0, b}, 16'h00A0, 2, "R2 overrun sticky");
            wr(4'd4, 8'h00);
            rd(4'd2, b);
            check({8'd0, b}, 16'h0000, 7, "R7 clears overrun");
            // R4: wrap through zero
            wr(4'd8, 8'h01); wr(4'd9, 8'h00);
            push(16'h0A0A);
            rd(4'd8, lo); rd(4'd9, hi);
            check({hi, lo}, 16'h0001, 5, "R5 loaded 1");
            push(16'h0B0B);
            rd(4'd8, lo); rd(4'd9, hi);
            check({hi, lo}, 16'h0000, 4, "R4 down to 0");
            push(16'h0C0C);
            rd(4'd8, lo); rd(4'd9, hi);
            check({hi, lo}, 16'hFFFF, 4, "R4 wrap to FFFF");
            // R10: reset in mid-run
            wr(4'd5, 8'hF0);
            check({13'd0, irq_level}, 16'h0007, 9, "R9 irq_level port");
            rd(4'd5, b);
            check({8'd0, b}, 16'h00F0, 9, "R9 low bits zero");
            @(negedge clk); rst = 1'b1;
            @(negedge clk); rst = 1'b0;
            rd(4'd2, b);  check({8'd0, b}, 16'h0, 10, "R10 status");
            rd(4'd5, b);  check({8'd0, b}, 16'h0, 10, "R10 control");
            rd(4'd8, lo); rd(4'd9, hi);
            check({hi, lo}, 16'h0, 10, "R10 counter");
            rd(4'd3, b);  check({8'd0, b}, 16'h0, 10, "R10 unmapped");
            check({15'd0, irq_out}, 16'h0, 10, "R10 irq_out");
            check(data_out, 16'h0, 10, "R10 data_out");
            push(16'hAAAA);
            pop();
            check(data_out, 16'hAAAA, 10, "R10 buffer empty after reset");
        end

        done = 1;
        $display("Result: errors=%0d of %0d checks", errors, checks);
        $finish;
    end

    initial begin
        repeat (150000) @(posedge clk);
        if (!done) begin
            errors++;
            checks++;
            $display("FAIL watchdog expired actual=hung expected=done");
            $display("Result: errors=%0d of %0d checks", errors, checks);
            $finish;
        end
    end
endmodule